// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block runs the outbound command ring of an audio codec link controller. Software places 32-bit command words in a local ring memory of 256 entries and advances a write pointer. The engine owns a read pointer, walks it toward the write pointer and hands each command word to a link serializer over a valid/ready stream, together with the codec address taken from the top nibble of the word.

Both pointers name the last entry touched rather than the next free slot. Software first increments the write pointer modulo 256, then stores the word at that index, then publishes the new pointer value. The engine increments its read pointer before it reads. Clearing the read pointer is a two-step handshake: software sets a reset bit, sees it read back as set, then writes zero and sees zero. A small register port gives access to both pointers, a run control and a ring-size code.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset the write pointer (offset 0) reads 0x0000, the read pointer (offset 1) reads 0x0000, the control register (offset 2) reads 0x0000, the size register (offset 3) reads 0x0002, and cmd_valid_o is low.
- R2: While running, with the reset bit clear and read pointer different from the write pointer, the engine increments the read pointer modulo 256 and presents the ring word at the new index. Words leave in ring order and wrap from index 255 to index 0.
- R3: Once the read pointer equals the write pointer, no further word is presented and the read pointer holds its value.
- R4: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_data_o and cmd_codec_o stay unchanged.
- R5: cmd_codec_o equals bits 31:28 of the presented cmd_data_o.
- R6: Bit 1 of the control register is the run bit. While it is 0, no new word is fetched and the read pointer does not move.
- R7: Writing the read pointer register with bit 15 set clears the pointer to 0 and drops any word being presented; the register then reads 0x8000. A later write of 0 to that register ends the reset, and it then reads 0x0000.
- R8: Writes to the write pointer are ignored while the read pointer reset bit (bit 15) is set.
- R9: ring_full_o is high exactly when (write pointer + 1) mod 256 equals the read pointer.
- R10: While pwr_down_i is high, reads of offsets 0 and 1 return 0xFFFF.
- R11: Offset 3 stores bits 1:0 of a write and reads them back in bits 1:0. The code 0x02 stands for 256 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Controller powered down; pointer reads return all ones |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset: 0 write ptr, 1 read ptr, 2 control, 3 size |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i (combinational) |
| ring_we_i | input | 1 | Ring memory write strobe |
| ring_waddr_i | input | 8 | Ring memory write index |
| ring_wdata_i | input | 32 | Ring memory write word |
| cmd_valid_o | output | 1 | Command word valid toward serializer |
| cmd_ready_i | input | 1 | Serializer accepts the word |
| cmd_data_o | output | 32 | Command word |
| cmd_codec_o | output | 4 | Target codec address |
| ring_full_o | output | 1 | Ring full |

## Verification
A read pointer that advances wrongly shows up on the stream within one transfer as a word out of ring order, or as an extra word past the write pointer. A lost handshake state shows as a word that changes or disappears while ready is low. The pointer reset and write-ignore rules show up at once on register read-back, and the full flag shows a pointer relation error in the same cycle. Long batches that cross the 255-to-0 wrap under a changing ready pattern expose off-by-one pointer faults within a few words.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  localparam int REG_W = 16;
  localparam logic [1:0] OFS_WP   = 2'd0;
  localparam logic [1:0] OFS_RP   = 2'd1;
  localparam logic [1:0] OFS_CTL  = 2'd2;
  localparam logic [1:0] OFS_SIZE = 2'd3;
  localparam int RP_RST_BIT = 15;
  localparam int RUN_BIT    = 1;
  localparam logic [1:0] SIZE_RST = 2'd2;
  localparam int CODEC_W = 4;
endpackage

// File: rtl/cmd_ring_mem.sv
module cmd_ring_mem #(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << PTR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [PTR_W-1:0] wp_o,
  output logic             run_o,
  output logic             rp_rst_o,
  output logic             rp_clr_o,
  output logic [1:0]       size_o
);
  logic [PTR_W-1:0] wp_q;
  logic             run_q, rst_q;
  logic [1:0]       size_q;
  logic             wr_wp, wr_rp, wr_ctl, wr_size;

  assign wr_wp   = reg_we_i && reg_addr_i == OFS_WP;
  assign wr_rp   = reg_we_i && reg_addr_i == OFS_RP;
  assign wr_ctl  = reg_we_i && reg_addr_i == OFS_CTL;
  assign wr_size = reg_we_i && reg_addr_i == OFS_SIZE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      run_q  <= 1'b0;
      rst_q  <= 1'b0;
      size_q <= SIZE_RST;
    end else begin
      if (wr_wp && !rst_q) wp_q <= reg_wdata_i[PTR_W-1:0];
      if (wr_rp)   rst_q  <= reg_wdata_i[RP_RST_BIT];
      if (wr_ctl)  run_q  <= reg_wdata_i[RUN_BIT];
      if (wr_size) size_q <= reg_wdata_i[1:0];
    end
  end

  assign wp_o     = wp_q;
  assign run_o    = run_q;
  assign rp_rst_o = rst_q;
  assign rp_clr_o = wr_rp && reg_wdata_i[RP_RST_BIT];
  assign size_o   = size_q;

  p_wp_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> $stable(wp_q));
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch #(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              hold_i,
  input  logic              clr_i,
  input  logic [PTR_W-1:0]  wp_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [PTR_W-1:0]  mem_raddr_o,
  output logic [PTR_W-1:0]  rp_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [DATA_W-1:0] cmd_data_o
);
  logic [PTR_W-1:0]  rp_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              fetch;

  assign mem_raddr_o = rp_q + 1'b1;  // pre-increment: read the entry after the last consumed
  assign fetch = run_i && !hold_i && !clr_i && (rp_q != wp_i) && (!valid_q || cmd_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (clr_i) begin
      rp_q    <= '0;
      valid_q <= 1'b0;
    end else if (fetch) begin
      rp_q    <= mem_raddr_o;
      data_q  <= mem_rdata_i;
      valid_q <= 1'b1;
    end else if (cmd_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign rp_o        = rp_q;
  assign cmd_valid_o = valid_q;
  assign cmd_data_o  = data_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !cmd_ready_i && !clr_i) |=> (valid_q && $stable(data_q)));
  p_no_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rp_q == wp_i && !clr_i) |=> $stable(rp_q));
  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(rp_q));
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rp_q == '0 && !valid_q));
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_down_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              ring_we_i,
  input  logic [PTR_W-1:0]  ring_waddr_i,
  input  logic [DATA_W-1:0] ring_wdata_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [CODEC_W-1:0] cmd_codec_o,
  output logic              ring_full_o
);
  localparam int PAD_W = REG_W - 1 - PTR_W;

  logic [PTR_W-1:0]  wp, rp, raddr;
  logic              run, rp_rst, rp_clr;
  logic [1:0]        size;
  logic [DATA_W-1:0] rdata;

  cmd_ring_regs #(.PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .wp_o(wp), .run_o(run), .rp_rst_o(rp_rst), .rp_clr_o(rp_clr), .size_o(size)
  );

  cmd_ring_mem #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .we_i(ring_we_i), .waddr_i(ring_waddr_i), .wdata_i(ring_wdata_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  cmd_ring_fetch #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_fetch (
    .clk_i, .rst_ni, .run_i(run), .hold_i(rp_rst), .clr_i(rp_clr), .wp_i(wp),
    .mem_rdata_i(rdata), .mem_raddr_o(raddr), .rp_o(rp),
    .cmd_valid_o, .cmd_ready_i, .cmd_data_o
  );

  assign cmd_codec_o = cmd_data_o[DATA_W-1 -: CODEC_W];
  assign ring_full_o = (PTR_W'(wp + 1'b1) == rp);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_WP:   reg_rdata_o = pwr_down_i ? '1 : REG_W'(wp);
      OFS_RP:   reg_rdata_o = pwr_down_i ? '1 : {rp_rst, {PAD_W{1'b0}}, rp};
      OFS_CTL:  reg_rdata_o[RUN_BIT] = run;
      default:  reg_rdata_o[1:0] = size;
    endcase
  end

  p_full_rel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_full_o |-> (rp != wp));
endmodule

// File: tb/cmd_ring_engine_bench.sv
`timescale 1ns/1ps
module cmd_ring_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwr_down_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = 16'd0;
  logic [15:0] reg_rdata_o;
  logic        ring_we_i = 1'b0;
  logic [7:0]  ring_waddr_i = 8'd0;
  logic [31:0] ring_wdata_i = 32'd0;
  logic        cmd_valid_o;
  logic        cmd_ready_i = 1'b0;
  logic [31:0] cmd_data_o;
  logic [3:0]  cmd_codec_o;
  logic        ring_full_o;

  int checks = 0;
  int errors = 0;
  int sw_wp = 0;
  int seq = 0;

  always #2.5 clk_i = ~clk_i;

  cmd_ring_engine u_cmd_ring_engine (.*);

  function automatic logic [31:0] cmd_word(input int k);
    return {4'(k * 7 + 3), 28'(k * 32'h9E37 + 5)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic ring_wr(input int idx, input logic [31:0] d);
    @(negedge clk_i);
    ring_we_i = 1'b1; ring_waddr_i = 8'(idx); ring_wdata_i = d;
    @(negedge clk_i);
    ring_we_i = 1'b0;
  endtask

  // push n words, software order: bump index, store, publish pointer
  task automatic push(input int n);
    for (int j = 0; j < n; j++) begin
      sw_wp = (sw_wp + 1) % 256;
      ring_wr(sw_wp, cmd_word(seq + j));
    end
    reg_wr(2'd0, 16'(sw_wp));
  endtask

  task automatic collect(input int n, input int phase);
    int got = 0;
    int cyc = 0;
    while (got < n && cyc < 2000) begin
      @(negedge clk_i);
      cmd_ready_i = ((cyc + phase) % 3) != 0;
      #1;
      if (cmd_valid_o && cmd_ready_i) begin
        check("R2 order", cmd_data_o, cmd_word(seq + got));
        check("R5 codec", 32'(cmd_codec_o), 32'(cmd_data_o[31:28]));
        got++;
      end
      cyc++;
    end
    check("R2 count", 32'(got), 32'(n));
    seq += n;
    @(negedge clk_i);
    cmd_ready_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [31:0] held;
    int rpv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    reg_rd(2'd0, rd); check("R1 wp", 32'(rd), 32'h0);
    reg_rd(2'd1, rd); check("R1 rp", 32'(rd), 32'h0);
    reg_rd(2'd2, rd); check("R1 ctl", 32'(rd), 32'h0);
    reg_rd(2'd3, rd); check("R1 size", 32'(rd), 32'h2);
    check("R1 valid", 32'(cmd_valid_o), 32'h0);
    check("R9 not full at reset", 32'(ring_full_o), 32'h0);

    reg_wr(2'd2, 16'h0002);
    // sweep crossing the 255->0 wrap with varying backpressure
    for (int b = 0; b < 20; b++) begin
      int n = (b * 13) % 29 + 1;
      push(n);
      collect(n, b);
      repeat (4) @(negedge clk_i);
      #1 check("R3 no extra word", 32'(cmd_valid_o), 32'h0);
      reg_rd(2'd1, rd); check("R3 rp at wp", 32'(rd), 32'(sw_wp));
    end

    // hold under backpressure
    push(1);
    repeat (3) @(negedge clk_i);
    #1 held = cmd_data_o;
    check("R4 valid", 32'(cmd_valid_o), 32'h1);
    repeat (4) @(negedge clk_i);
    #1 check("R4 stable data", cmd_data_o, held);
    check("R4 still valid", 32'(cmd_valid_o), 32'h1);
    check("R4 word", held, cmd_word(seq));
    collect(1, 1);

    // stop
    reg_wr(2'd2, 16'h0000);
    reg_rd(2'd2, rd); check("R6 ctl read", 32'(rd), 32'h0);
    rpv = sw_wp;
    push(3);
    repeat (6) @(negedge clk_i);
    #1 check("R6 no fetch", 32'(cmd_valid_o), 32'h0);
    reg_rd(2'd1, rd); check("R6 rp stable", 32'(rd), 32'(rpv));

    // full rule
    reg_wr(2'd0, 16'((rpv + 255) % 256));
    #1 check("R9 full", 32'(ring_full_o), 32'h1);
    reg_wr(2'd0, 16'((rpv + 254) % 256));
    #1 check("R9 not full", 32'(ring_full_o), 32'h0);
    sw_wp = (rpv + 254) % 256;

    // reset handshake and write-ignore
    reg_wr(2'd1, 16'h8000);
    reg_rd(2'd1, rd); check("R7 reset readback", 32'(rd), 32'h8000);
    reg_wr(2'd0, 16'h0011);
    reg_rd(2'd0, rd); check("R8 wp write ignored", 32'(rd), 32'(sw_wp));
    reg_wr(2'd1, 16'h0000);
    reg_rd(2'd1, rd); check("R7 cleared readback", 32'(rd), 32'h0);
    check("R7 nothing presented", 32'(cmd_valid_o), 32'h0);
    sw_wp = 0;
    reg_wr(2'd0, 16'h0000);
    reg_wr(2'd2, 16'h0002);
    push(3);
    collect(3, 0);

    // power down read-back
    pwr_down_i = 1'b1;
    reg_rd(2'd0, rd); check("R10 wp pd", 32'(rd), 32'hFFFF);
    reg_rd(2'd1, rd); check("R10 rp pd", 32'(rd), 32'hFFFF);
    pwr_down_i = 1'b0;
    reg_rd(2'd1, rd); check("R10 rp after pd", 32'(rd), 32'h3);

    // size register
    reg_wr(2'd3, 16'h0001);
    reg_rd(2'd3, rd); check("R11 size 1", 32'(rd), 32'h1);
    reg_wr(2'd3, 16'h0002);
    reg_rd(2'd3, rd); check("R11 size 2", 32'(rd), 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule